// File: doc/BRIEF.md
# Microwire Serial EEPROM Block Reader

This block reads a run of consecutive 16-bit words from a Microwire serial EEPROM and hands them to the host. The host gives a start address, a word count and a one-clock `go_i` strobe. The block then runs one full read command frame per word. The serial clock comes from the system clock through a divider. Both phase lengths are derived from the `CLK_MHZ` parameter so that the device's minimum phase times are met. Each received word appears on `word_data_o` for one clock, qualified by `word_valid_o` and tagged with its 0-based position in the run.

A frame goes through the states SELECT, COMMAND, ADDRESS, DATA and TURN, in that order.
- **SELECT**: chip select rises and the block issues one full serial clock cycle with data out low.
- **COMMAND**: three cycles carry the start bit and the read opcode.
- **ADDRESS**: `ADDR_BITS` cycles carry the word address.
- **DATA**: seventeen cycles sample the device.
- **TURN**: chip select is dropped for one more clock cycle.

After TURN the controller goes back to SELECT for the next address, or goes to DONE after the last word. From IDLE, a strobe with a count of zero goes straight to DONE. DONE always goes back to IDLE after one clock.

The `ADDR_BITS` parameter selects a 6-bit or an 8-bit address. When `USE_READY` is 1, a low `rdy_i` holds the current clock phase open. When `USE_READY` is 0, `rdy_i` is ignored.

Top module: `uwire_seq_reader`

## Requirements
- R1: After reset and whenever idle, `cs_o`, `sck_o`, `sdo_o`, `busy_o`, `done_o` and `word_valid_o` are all 0.
- R2: A `go_i` pulse while idle latches the address and count, and `busy_o` is 1 from the next clock until the clock after `done_o`. A `go_i` pulse while busy has no effect on the run.
- R3: Every frame begins with `cs_o` rising while `sck_o` is low, followed by exactly one rising edge of `sck_o` with `sdo_o` = 0 before the start bit.
- R4: The next three rising edges carry `sdo_o` = 1, 1, 0: the start bit and then the read opcode 10.
- R5: The next `ADDR_BITS` rising edges carry the word address, most significant bit first.
- R6: Seventeen data cycles follow, each sampling `sdi_i` at the end of its high phase, with the samples shifted into a 16-bit register so that the first is lost. One clock after the 17th sample, `word_valid_o` pulses for one clock with the word (first device bit after the dummy 0 in bit 15) and its 0-based index.
- R7: After the 17th data cycle `cs_o` falls, and exactly one rising edge of `sck_o` with `cs_o` low occurs before the next frame or the end of the run.
- R8: Words are read from addresses start, start+1, … start+count−1, wrapping modulo 2^`ADDR_BITS`.
- R9: With `rdy_i` high, each low phase lasts ceil(250·`CLK_MHZ`/1000) clocks and each high phase lasts ceil(750·`CLK_MHZ`/1000) clocks. With `CLK_MHZ`=16 these are 4 and 12 clocks.
- R10: `sdo_o` changes only while `sck_o` is low, so it is stable across each rising edge and throughout the high phase.
- R11: When `USE_READY`=1, no clock phase ends while `rdy_i` is low. When `USE_READY`=0, `rdy_i` has no effect.
- R12: `done_o` is a single-clock pulse after the final TURN cycle. A count of 0 produces `done_o` without any frame.
- R13: With `ADDR_BITS`=8, frames carry 8 address bits and the count port allows up to 256 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start strobe, one clock |
| start_addr_i | input | ADDR_BITS | First word address |
| word_count_i | input | ADDR_BITS+1 | Number of words to read |
| rdy_i | input | 1 | Phase-stretch enable, low holds the current phase |
| sdi_i | input | 1 | Serial data from the device |
| cs_o | output | 1 | Device chip select |
| sck_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data to the device |
| word_valid_o | output | 1 | Word strobe |
| word_data_o | output | 16 | Received word |
| word_idx_o | output | ADDR_BITS+1 | Index of the word within the run |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | End-of-run pulse |

## Verification
Timing of the results:
- `busy_o` is due one clock after the `go_i` edge.
- Each word strobe is due one clock after the end of the 17th data high phase.
- `done_o` is due one clock after the TURN high phase of the last word.

The bench drives inputs and samples outputs on the falling clock edge, so each result is seen in the cycle it is registered. The bench waits on `done_o` rather than on a fixed cycle count, because phases stretch under `rdy_i`. Frame contents are checked at the serial pins by a device model, which decodes each frame on the rising edges of `sck_o`. Phase lengths and `sdo_o` stability are measured by counting system clocks between transitions of `sck_o`.

// File: rtl/uwire_rd_pkg.sv
package uwire_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_COMMAND,
        ST_ADDRESS,
        ST_DATA,
        ST_TURN,
        ST_DONE
    } rd_state_t;

    localparam int WORD_W      = 16;
    localparam int DATA_CYCLES = WORD_W + 1;
    localparam int CMD_BITS    = 3;
    localparam logic [CMD_BITS-1:0] READ_CMD = 3'b110;
    localparam int T_LOW_NS    = 250;
    localparam int T_HIGH_NS   = 750;

    function automatic int ticks_for(input int ns, input int mhz);
        int t;
        t = (ns * mhz + 999) / 1000;
        return (t < 1) ? 1 : t;
    endfunction

endpackage

// File: rtl/uwire_phase_timer.sv
module uwire_phase_timer
    import uwire_rd_pkg::*;
#(
    parameter int LO_TICKS  = 4,
    parameter int HI_TICKS  = 12,
    parameter bit USE_READY = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rdy_i,
    output logic phase_hi,
    output logic bit_end
);
    localparam int MAXT = (HI_TICKS > LO_TICKS) ? HI_TICKS : LO_TICKS;
    localparam int CW   = (MAXT < 2) ? 1 : $clog2(MAXT);

    logic [CW-1:0] cnt_q;
    logic          phase_q;
    logic          rdy_ok;
    logic [CW-1:0] limit;
    logic          at_limit;
    logic          step_end;

    generate
        if (USE_READY) begin : g_rdy
            assign rdy_ok = rdy_i;
        end else begin : g_nordy
            logic unused_rdy;
            assign unused_rdy = rdy_i;
            assign rdy_ok     = 1'b1;
        end
    endgenerate

    assign limit    = phase_q ? CW'(HI_TICKS - 1) : CW'(LO_TICKS - 1);
    assign at_limit = (cnt_q == limit);
    assign step_end = at_limit && rdy_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (!run) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (step_end) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else if (!at_limit) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign phase_hi = phase_q;
    assign bit_end  = run && phase_q && step_end;

    // R9
    lo_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_q) |-> $past(cnt_q) == CW'(LO_TICKS - 1));

    // R9
    hi_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(phase_q) && $past(run)) |-> $past(cnt_q) == CW'(HI_TICKS - 1));

    // R11
    rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(rdy_ok)) |-> phase_q == $past(phase_q));

endmodule

// File: rtl/uwire_rx_shift.sv
module uwire_rx_shift
    import uwire_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              last_sample,
    input  logic              sdi_i,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data
);
    logic [WORD_W-1:0] sh_q;
    logic              vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            vld_q <= 1'b0;
        end else begin
            if (sample_en) begin
                sh_q <= {sh_q[WORD_W-2:0], sdi_i};
            end
            vld_q <= sample_en && last_sample;
        end
    end

    assign word_valid = vld_q;
    assign word_data  = sh_q;

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

endmodule

// File: rtl/uwire_seq_fsm.sv
module uwire_seq_fsm
    import uwire_rd_pkg::*;
#(
    parameter int ADDR_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go_i,
    input  logic [ADDR_BITS-1:0] start_addr_i,
    input  logic [ADDR_BITS:0]   word_count_i,
    input  logic                 bit_end,
    output logic                 run,
    output logic                 cs_o,
    output logic                 sdo_o,
    output logic                 sample_en,
    output logic                 last_sample,
    output logic [ADDR_BITS:0]   idx_o,
    output logic                 busy_o,
    output logic                 done_o
);
    localparam int CNT_W = ADDR_BITS + 1;
    localparam int BCW   = $clog2(DATA_CYCLES);
    localparam int AIW   = $clog2(ADDR_BITS);

    rd_state_t             state_q, state_d;
    logic [BCW-1:0]        bit_q, bit_d;
    logic [ADDR_BITS-1:0]  addr_q, addr_d;
    logic [CNT_W-1:0]      left_q, left_d;
    logic [CNT_W-1:0]      idx_q, idx_d;
    logic [1:0]            cmd_sel;
    logic [AIW-1:0]        addr_sel;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            addr_q  <= '0;
            left_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            addr_q  <= addr_d;
            left_q  <= left_d;
            idx_q   <= idx_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        addr_d  = addr_q;
        left_d  = left_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_i) begin
                    addr_d  = start_addr_i;
                    left_d  = word_count_i;
                    idx_d   = '0;
                    bit_d   = '0;
                    state_d = (word_count_i == '0) ? ST_DONE : ST_SELECT;
                end
            end
            ST_SELECT: begin
                if (bit_end) begin
                    bit_d   = '0;
                    state_d = ST_COMMAND;
                end
            end
            ST_COMMAND: begin
                if (bit_end) begin
                    if (bit_q == BCW'(CMD_BITS - 1)) begin
                        bit_d   = '0;
                        state_d = ST_ADDRESS;
                    end else begin
                        bit_d = bit_q + 1'b1;
                    end
                end
            end
            ST_ADDRESS: begin
                if (bit_end) begin
                    if (bit_q == BCW'(ADDR_BITS - 1)) begin
                        bit_d   = '0;
                        state_d = ST_DATA;
                    end else begin
                        bit_d = bit_q + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (bit_end) begin
                    if (bit_q == BCW'(DATA_CYCLES - 1)) begin
                        bit_d   = '0;
                        state_d = ST_TURN;
                    end else begin
                        bit_d = bit_q + 1'b1;
                    end
                end
            end
            ST_TURN: begin
                if (bit_end) begin
                    if (left_q == CNT_W'(1)) begin
                        state_d = ST_DONE;
                    end else begin
                        addr_d  = addr_q + 1'b1;
                        left_d  = left_q - 1'b1;
                        idx_d   = idx_q + 1'b1;
                        state_d = ST_SELECT;
                    end
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign cmd_sel  = 2'(CMD_BITS - 1) - bit_q[1:0];
    assign addr_sel = AIW'(ADDR_BITS - 1) - bit_q[AIW-1:0];

    // outputs
    always_comb begin
        cs_o        = 1'b0;
        sdo_o       = 1'b0;
        run         = 1'b0;
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_DONE);
        sample_en   = 1'b0;
        last_sample = (bit_q == BCW'(DATA_CYCLES - 1));
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                run = 1'b0;
            end
            ST_SELECT: begin
                cs_o = 1'b1;
                run  = 1'b1;
            end
            ST_COMMAND: begin
                cs_o  = 1'b1;
                run   = 1'b1;
                sdo_o = READ_CMD[cmd_sel];
            end
            ST_ADDRESS: begin
                cs_o  = 1'b1;
                run   = 1'b1;
                sdo_o = addr_q[addr_sel];
            end
            ST_DATA: begin
                cs_o      = 1'b1;
                run       = 1'b1;
                sample_en = bit_end;
            end
            ST_TURN: begin
                run = 1'b1;
            end
            default: begin
                run = 1'b0;
            end
        endcase
    end

    assign idx_o = idx_q;

    // R7
    cs_fall_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_o) |-> state_q == ST_TURN);

    // R2
    go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && state_q == ST_DATA && !bit_end) |=> $stable(addr_q) && $stable(left_q));

endmodule

// File: rtl/uwire_seq_reader.sv
module uwire_seq_reader
    import uwire_rd_pkg::*;
#(
    parameter int ADDR_BITS = 6,
    parameter int CLK_MHZ   = 200,
    parameter bit USE_READY = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go_i,
    input  logic [ADDR_BITS-1:0] start_addr_i,
    input  logic [ADDR_BITS:0]   word_count_i,
    input  logic                 rdy_i,
    input  logic                 sdi_i,
    output logic                 cs_o,
    output logic                 sck_o,
    output logic                 sdo_o,
    output logic                 word_valid_o,
    output logic [15:0]          word_data_o,
    output logic [ADDR_BITS:0]   word_idx_o,
    output logic                 busy_o,
    output logic                 done_o
);
    localparam int LO_TICKS = ticks_for(T_LOW_NS, CLK_MHZ);
    localparam int HI_TICKS = ticks_for(T_HIGH_NS, CLK_MHZ);

    logic run;
    logic phase_hi;
    logic bit_end;
    logic sample_en;
    logic last_sample;

    uwire_seq_fsm #(.ADDR_BITS(ADDR_BITS)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (go_i),
        .start_addr_i (start_addr_i),
        .word_count_i (word_count_i),
        .bit_end      (bit_end),
        .run          (run),
        .cs_o         (cs_o),
        .sdo_o        (sdo_o),
        .sample_en    (sample_en),
        .last_sample  (last_sample),
        .idx_o        (word_idx_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    uwire_phase_timer #(
        .LO_TICKS  (LO_TICKS),
        .HI_TICKS  (HI_TICKS),
        .USE_READY (USE_READY)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .rdy_i    (rdy_i),
        .phase_hi (phase_hi),
        .bit_end  (bit_end)
    );

    uwire_rx_shift rx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_en   (sample_en),
        .last_sample (last_sample),
        .sdi_i       (sdi_i),
        .word_valid  (word_valid_o),
        .word_data   (word_data_o)
    );

    assign sck_o = run && phase_hi;

    // R10
    sdo_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> $stable(sdo_o));

    // R3
    cs_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_o) |-> !sck_o);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    busy_after_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !busy_o) |=> busy_o);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!cs_o && !sck_o && !sdo_o && !word_valid_o));

endmodule

// File: tb/uwire_seq_reader_tb_top.sv
`timescale 1ns/1ps

module uwire_eeprom_model #(
    parameter int AW = 6
) (
    input  logic cs_i,
    input  logic sck_i,
    input  logic sdo_i,
    output logic sdi_o,
    output int   bad_o,
    output int   frames_o
);
    logic          cs_q = 1'b0;
    logic          seen = 1'b0;
    logic          started = 1'b0;
    int            lead = 0;
    int            hdr_n = 0;
    int            dat_k = 0;
    int            low_edges = 0;
    logic [AW+1:0] hdr = '0;
    logic [15:0]   word = '0;

    function automatic logic [15:0] content(input int a);
        int v;
        v = (a * 40503 + 23100) ^ (a << 9);
        return v[15:0];
    endfunction

    initial begin
        sdi_o    = 1'b0;
        bad_o    = 0;
        frames_o = 0;
    end

    always @(cs_i or posedge sck_i) begin
        if (cs_i !== cs_q) begin
            cs_q = cs_i;
            if (cs_i === 1'b1) begin
                if (seen && low_edges != 1) bad_o++;
                seen    = 1'b1;
                lead    = 0;
                started = 1'b0;
                hdr_n   = 0;
                dat_k   = 0;
            end else if (seen) begin
                if (!(started && lead == 1 && hdr_n == AW + 2 && dat_k == 17 &&
                      hdr[AW+1:AW] == 2'b10)) bad_o++;
                frames_o++;
                low_edges = 0;
                sdi_o     = 1'b0;
            end
        end else if (sck_i === 1'b1) begin
            if (cs_i !== 1'b1) begin
                low_edges++;
            end else if (!started) begin
                if (sdo_i) started = 1'b1;
                else lead++;
            end else if (hdr_n < AW + 2) begin
                hdr = {hdr[AW:0], sdo_i};
                hdr_n++;
                if (hdr_n == AW + 2) word = content(int'(hdr[AW-1:0]));
            end else begin
                if (dat_k == 0) sdi_o = 1'b0;
                else if (dat_k <= 16) sdi_o = word[16-dat_k];
                dat_k++;
            end
        end
    end
endmodule

module uwire_seq_reader_tb_top;
    localparam int MHZ = 16;
    localparam int LO  = (250 * MHZ + 999) / 1000;
    localparam int HI  = (750 * MHZ + 999) / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        go6 = 1'b0, go8 = 1'b0, rdy = 1'b1;
    logic [5:0]  sa6 = '0;
    logic [6:0]  cnt6 = '0;
    logic [7:0]  sa8 = '0;
    logic [8:0]  cnt8 = '0;
    logic        cs6, sck6, sdo6, sdi6, v6, busy6, dn6;
    logic        cs8, sck8, sdo8, sdi8, v8, busy8, dn8;
    logic [15:0] d6, d8;
    logic [6:0]  i6;
    logic [8:0]  i8;
    int          bad6, fr6, bad8, fr8;

    uwire_seq_reader #(.ADDR_BITS(6), .CLK_MHZ(MHZ), .USE_READY(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .go_i(go6), .start_addr_i(sa6), .word_count_i(cnt6),
        .rdy_i(rdy), .sdi_i(sdi6), .cs_o(cs6), .sck_o(sck6), .sdo_o(sdo6),
        .word_valid_o(v6), .word_data_o(d6), .word_idx_o(i6), .busy_o(busy6), .done_o(dn6));

    uwire_seq_reader #(.ADDR_BITS(8), .CLK_MHZ(MHZ), .USE_READY(1'b0)) dut8_i (
        .clk(clk), .rst_n(rst_n), .go_i(go8), .start_addr_i(sa8), .word_count_i(cnt8),
        .rdy_i(rdy), .sdi_i(sdi8), .cs_o(cs8), .sck_o(sck8), .sdo_o(sdo8),
        .word_valid_o(v8), .word_data_o(d8), .word_idx_o(i8), .busy_o(busy8), .done_o(dn8));

    uwire_eeprom_model #(.AW(6)) m6_i (.cs_i(cs6), .sck_i(sck6), .sdo_i(sdo6),
        .sdi_o(sdi6), .bad_o(bad6), .frames_o(fr6));
    uwire_eeprom_model #(.AW(8)) m8_i (.cs_i(cs8), .sck_i(sck8), .sdo_i(sdo8),
        .sdi_o(sdi8), .bad_o(bad8), .frames_o(fr8));

    int checks = 0, fails = 0, cyc = 0;
    int nw = 0, ndone = 0;
    int got_d[256];
    int got_i[256];
    int min_lo, max_lo, min_hi, max_hi, runlen = 0, sdo_viol = 0;
    logic prev_sck = 1'b0, prev_sdo = 1'b0;
    logic stall_en = 1'b0;
    int sctr = 0;

    function automatic int expect_word(input int a);
        int v;
        v = (a * 40503 + 23100) ^ (a << 9);
        return v & 16'hFFFF;
    endfunction

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic reset_widths();
        min_lo = 1000000; max_lo = 0; min_hi = 1000000; max_hi = 0; sdo_viol = 0;
    endtask

    always @(negedge clk) begin
        if (v6 || v8) begin
            if (nw < 256) begin
                got_d[nw] = v6 ? int'(d6) : int'(d8);
                got_i[nw] = v6 ? int'(i6) : int'(i8);
            end
            nw++;
        end
        if (dn6 || dn8) ndone++;
        if (stall_en) begin
            sctr++;
            rdy = (sctr % 7) < 4;
        end
        if (!busy6) begin
            runlen = 0;
            prev_sck = 1'b0;
        end else begin
            if (sck6 && prev_sck && sdo6 != prev_sdo) sdo_viol++;
            if (sck6 == prev_sck) runlen++;
            else begin
                if (prev_sck) begin
                    if (runlen < min_hi) min_hi = runlen;
                    if (runlen > max_hi) max_hi = runlen;
                end else begin
                    if (runlen < min_lo) min_lo = runlen;
                    if (runlen > max_lo) max_lo = runlen;
                end
                prev_sck = sck6;
                runlen = 1;
            end
        end
        prev_sdo = sdo6;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog expired actual=busy expected=idle");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // mode: 0 plain, 1 ready toggling, 2 ready frozen mid-run, 3 go while busy
    task automatic run_seq(input bit use8, input int sa, input int cnt, input int mode);
        int bad0, fr0, depth, wrapped, sck0, changes;
        depth = use8 ? 256 : 64;
        bad0 = use8 ? bad8 : bad6;
        fr0  = use8 ? fr8 : fr6;
        @(negedge clk);
        nw = 0;
        ndone = 0;
        if (use8) begin
            sa8 = 8'(sa); cnt8 = 9'(cnt); go8 = 1'b1;
        end else begin
            sa6 = 6'(sa); cnt6 = 7'(cnt); go6 = 1'b1;
        end
        if (mode == 1) stall_en = 1'b1;
        @(negedge clk);
        go6 = 1'b0;
        go8 = 1'b0;
        check_eq("R2", "busy one clock after go", int'(use8 ? busy8 : busy6), 1);
        if (mode == 2) begin
            repeat (300) @(negedge clk);
            rdy = 1'b0;
            sck0 = int'(sck6);
            changes = 0;
            repeat (40) begin
                @(negedge clk);
                if (int'(sck6) != sck0) changes++;
            end
            check_eq("R11", "sck transitions while ready low", changes, 0);
            rdy = 1'b1;
        end
        if (mode == 3) begin
            repeat (200) @(negedge clk);
            sa6 = 6'(sa + 17);
            cnt6 = 7'(cnt + 3);
            go6 = 1'b1;
            @(negedge clk);
            go6 = 1'b0;
        end
        while (ndone == 0) @(negedge clk);
        stall_en = 1'b0;
        rdy = use8 ? 1'b0 : 1'b1;
        @(negedge clk);
        check_eq("R12", "done pulses", ndone, 1);
        check_eq("R2", "busy after done", int'(use8 ? busy8 : busy6), 0);
        check_eq("R6", "word strobes", nw, cnt);
        for (int k = 0; k < cnt && k < 256; k++) begin
            wrapped = (sa + k) % depth;
            check_eq("R5/R8", $sformatf("word %0d data", k), got_d[k], expect_word(wrapped));
            check_eq("R6", $sformatf("word %0d index", k), got_i[k], k);
        end
        check_eq("R3/R4/R5/R7", "frame protocol errors",
                 (use8 ? bad8 : bad6) - bad0, 0);
        check_eq("R7", "frames", (use8 ? fr8 : fr6) - fr0, cnt);
        check_eq("R1", "cs idle", int'(use8 ? cs8 : cs6), 0);
        check_eq("R1", "sck idle", int'(use8 ? sck8 : sck6), 0);
        check_eq("R1", "sdo idle", int'(use8 ? sdo8 : sdo6), 0);
    endtask

    initial begin
        reset_widths();
        repeat (5) @(negedge clk);
        check_eq("R1", "reset busy", int'(busy6), 0);
        check_eq("R1", "reset cs", int'(cs6), 0);
        check_eq("R1", "reset sck", int'(sck6), 0);
        check_eq("R1", "reset valid", int'(v6), 0);
        check_eq("R1", "reset done", int'(dn6), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        reset_widths();
        run_seq(1'b0, 0, 3, 0);
        check_eq("R9", "min low phase", min_lo, LO);
        check_eq("R9", "max low phase", max_lo, LO);
        check_eq("R9", "min high phase", min_hi, HI);
        check_eq("R9", "max high phase", max_hi, HI);
        check_eq("R10", "sdo changes in high phase", sdo_viol, 0);

        run_seq(1'b0, 61, 5, 0);
        run_seq(1'b0, 17, 1, 0);
        run_seq(1'b0, 5, 0, 0);
        run_seq(1'b0, 10, 64, 0);

        reset_widths();
        run_seq(1'b0, 33, 2, 1);
        check_eq("R11", "stretched high phase seen", int'(max_hi > HI), 1);
        check_eq("R11", "no short high phase", int'(min_hi >= HI), 1);
        check_eq("R10", "sdo changes under stall", sdo_viol, 0);

        run_seq(1'b0, 40, 2, 2);
        run_seq(1'b0, 20, 2, 3);

        rdy = 1'b0;
        run_seq(1'b1, 250, 10, 0);
        run_seq(1'b1, 3, 0, 0);
        check_eq("R13", "wide index after wrap run", int'(i8), 0);
        rdy = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule